// File: doc/BRIEF.md
# Prescaled Event Interrupt Timer

This block is an interrupt timer of the kind found on game cartridges. It has an 8-bit prescaler that feeds an 8-bit main counter. Both count in the same direction, either up or down, and the direction is chosen at run time. The prescaler advances on one of four event sources, and each source arrives as a one-cycle strobe:

- CPU cycles;
- rising edges on the pattern-table address line;
- changes of the picture-fetch address;
- CPU write cycles.

When the main counter wraps and interrupts are enabled, a level interrupt output is raised. It stays high until software acknowledges it.

Software programs the block through eight byte-wide registers, selected by a 3-bit offset. Values written to the two counters are first XORed with a key held in a separate register. The prescaler's carry width can be a full byte or three bits. A mode bit can replace both of those widths with a software-supplied mask. Bus decoding above the register offset lies outside the block.

Top module: `irq_prescale_timer`

## Requirements
- R1: After reset, irq is low and every register is zero: counters, mode, key, mask byte, enable and the last fetch address. With mode zero the counters are frozen, so no strobe can raise irq until software writes the mode.
- R2: Offset 1 holds the mode byte. Mode bits 7:6 set the direction: 2'b01 counts up and 2'b10 counts down.
- R3: When mode bits 7:6 are 2'b00 or 2'b11, neither counter moves, whatever strobes arrive.
- R4: Mode bits 1:0 choose the event source. Value 0 selects cpuCycleStb, 1 selects a12RiseStb and 3 selects cpuWriteStb. Each strobe of the selected source advances the prescaler once. Strobes from sources that are not selected have no effect.
- R5: Source value 2 selects fetchStb. A fetch whose fetchAddr differs from the address of the previous fetchStb advances the prescaler twice in that cycle. A fetch at the same address does not advance it. The previous address is recorded on every fetchStb in every mode, and it resets to 0.
- R6: A write to offset 4 loads the prescaler and a write to offset 5 loads the main counter. In both cases the value stored is wrData XOR the key byte last written to offset 6.
- R7: Counting up, each advance increments the prescaler. If the incremented prescaler ANDed with the mask is zero, the main counter increments. A main counter that goes from 0xFF to 0x00 is a wrap event.
- R8: Counting down, each advance decrements the prescaler. If the decremented prescaler ANDed with the mask equals the mask, the main counter decrements. A main counter that goes from 0x00 to 0xFF is a wrap event.
- R9: The prescaler mask is 0x07 when mode bit 2 is set and 0xFF when it is clear. When mode bit 3 is set, the mask is the byte written to offset 7 instead, whatever bit 2 holds.
- R10: A wrap event sets irq when the enable held before that cycle's write is 1. Once set, irq stays high until it is acknowledged.
- R11: A write to offset 0 copies wrData bit 0 into the enable, and when that bit is 0 the write also acknowledges (clears) irq. A write to offset 2 clears the enable and acknowledges. A write to offset 3 sets the enable without acknowledging. An acknowledge wins over a wrap event in the same cycle.
- R12: If a counter load (offset 4 or 5) falls in the same cycle as an advance strobe, the advance is dropped. The loaded counter takes the new value and the other counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register offset |
| wrData | input | 8 | Write data |
| cpuCycleStb | input | 1 | One pulse per CPU cycle |
| a12RiseStb | input | 1 | One pulse per rising edge of the pattern-table address line |
| fetchStb | input | 1 | One pulse per picture-memory fetch |
| fetchAddr | input | 14 | Address of the fetch marked by fetchStb |
| cpuWriteStb | input | 1 | One pulse per CPU write cycle |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check four things:
- a load stores the keyed value and leaves the other counter untouched;
- both counters hold still when no advance arrives;
- an acknowledge leaves irq low in the next cycle;
- irq can rise only while the enable is set.

Other behaviour can only be shown by the bench's scenarios, which compare irq against a reference model at every cycle. These cover the exact cycle of each wrap for all three mask choices in both directions, the double advance on fetch-address changes, the rejection of unselected sources, and the ordering of enable, acknowledge and wrap within one cycle.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;
  localparam int CNT_W = 8;
  localparam int NARROW_BITS = 3;
  localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((1 << NARROW_BITS) - 1);

  // register offsets
  localparam logic [2:0] OFS_ENA   = 3'd0;
  localparam logic [2:0] OFS_MODE  = 3'd1;
  localparam logic [2:0] OFS_OFF   = 3'd2;
  localparam logic [2:0] OFS_ON    = 3'd3;
  localparam logic [2:0] OFS_PRE   = 3'd4;
  localparam logic [2:0] OFS_MAIN  = 3'd5;
  localparam logic [2:0] OFS_KEY   = 3'd6;
  localparam logic [2:0] OFS_ADJ   = 3'd7;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_A12   = 2'd1,
    SRC_FETCH = 2'd2,
    SRC_WRITE = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic             loadPre;
    logic             loadMain;
    logic [CNT_W-1:0] loadVal;
    logic [1:0]       steps;
    logic             countUp;
    logic [CNT_W-1:0] preMask;
    logic             enable;
    logic             ack;
  } tmrCtl_t;
endpackage

// File: rtl/irq_tmr_ctrl.sv
module irq_tmr_ctrl
  import irq_tmr_pkg::*;
#(
  parameter int FETCH_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               cpuCycleStb,
  input  logic               a12RiseStb,
  input  logic               fetchStb,
  input  logic [FETCH_W-1:0] fetchAddr,
  input  logic               cpuWriteStb,
  output tmrCtl_t            ctl
);
  logic [CNT_W-1:0]   modeQ, keyQ, adjQ;
  logic               enQ;
  logic [FETCH_W-1:0] lastFetchQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ      <= '0;
      keyQ       <= '0;
      adjQ       <= '0;
      enQ        <= 1'b0;
      lastFetchQ <= '0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          OFS_ENA:  enQ   <= wrData[0];
          OFS_MODE: modeQ <= wrData;
          OFS_OFF:  enQ   <= 1'b0;
          OFS_ON:   enQ   <= 1'b1;
          OFS_KEY:  keyQ  <= wrData;
          OFS_ADJ:  adjQ  <= wrData;
          default:  ;
        endcase
      end
      if (fetchStb) lastFetchQ <= fetchAddr;
    end
  end

  logic       dirUp, dirDown, anyLoad;
  logic [1:0] srcSteps;
  srcSel_e    src;

  always_comb begin
    dirUp   = (modeQ[7:6] == 2'b01);
    dirDown = (modeQ[7:6] == 2'b10);
    src     = srcSel_e'(modeQ[1:0]);
    anyLoad = wrEn && ((wrAddr == OFS_PRE) || (wrAddr == OFS_MAIN));
    case (src)
      SRC_CPU:   srcSteps = {1'b0, cpuCycleStb};
      SRC_A12:   srcSteps = {1'b0, a12RiseStb};
      SRC_FETCH: srcSteps = (fetchStb && (fetchAddr != lastFetchQ)) ? 2'd2 : 2'd0;
      default:   srcSteps = {1'b0, cpuWriteStb};
    endcase

    ctl.loadPre  = wrEn && (wrAddr == OFS_PRE);
    ctl.loadMain = wrEn && (wrAddr == OFS_MAIN);
    ctl.loadVal  = wrData ^ keyQ;
    ctl.steps    = ((dirUp || dirDown) && !anyLoad) ? srcSteps : 2'd0;
    ctl.countUp  = dirUp;
    ctl.preMask  = modeQ[3] ? adjQ : (modeQ[2] ? NARROW_MASK : '1);
    ctl.enable   = enQ;
    ctl.ack      = wrEn && ((wrAddr == OFS_OFF) || ((wrAddr == OFS_ENA) && !wrData[0]));
  end

  // R12
  load_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (wrAddr == OFS_PRE || wrAddr == OFS_MAIN)) |-> (ctl.steps == 2'd0));
endmodule

// File: rtl/irq_tmr_core.sv
module irq_tmr_core
  import irq_tmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tmrCtl_t ctl,
  output logic    irq
);
  logic [CNT_W-1:0] preQ, mainQ;
  logic             irqQ;
  logic [CNT_W-1:0] preNext, mainNext;
  logic             wrapHit;

  // chained advances: up to two per cycle
  always_comb begin
    preNext  = preQ;
    mainNext = mainQ;
    wrapHit  = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (i < int'(ctl.steps)) begin
        if (ctl.countUp) begin
          preNext = preNext + 1'b1;
          if ((preNext & ctl.preMask) == '0) begin
            mainNext = mainNext + 1'b1;
            if (mainNext == '0) wrapHit = 1'b1;
          end
        end else begin
          preNext = preNext - 1'b1;
          if ((preNext & ctl.preMask) == ctl.preMask) begin
            mainNext = mainNext - 1'b1;
            if (mainNext == '1) wrapHit = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preQ  <= '0;
      mainQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      preQ  <= ctl.loadPre  ? ctl.loadVal : preNext;
      mainQ <= ctl.loadMain ? ctl.loadVal : mainNext;
      if (ctl.ack)                    irqQ <= 1'b0;
      else if (wrapHit && ctl.enable) irqQ <= 1'b1;
    end
  end

  assign irq = irqQ;

  // R6
  load_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadPre |=> (preQ == $past(ctl.loadVal)));
  // R6
  load_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadMain |=> (mainQ == $past(ctl.loadVal)));
  // R12
  load_keeps_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadPre |=> $stable(mainQ));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.steps == 2'd0 && !ctl.loadPre && !ctl.loadMain) |=> ($stable(preQ) && $stable(mainQ)));
  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ack |=> !irqQ);
  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqQ) |-> $past(ctl.enable));
endmodule

// File: rtl/irq_prescale_timer.sv
module irq_prescale_timer
  import irq_tmr_pkg::*;
#(
  parameter int FETCH_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               cpuCycleStb,
  input  logic               a12RiseStb,
  input  logic               fetchStb,
  input  logic [FETCH_W-1:0] fetchAddr,
  input  logic               cpuWriteStb,
  output logic               irq
);
  tmrCtl_t ctl;

  irq_tmr_ctrl #(.FETCH_W(FETCH_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpuCycleStb(cpuCycleStb), .a12RiseStb(a12RiseStb), .fetchStb(fetchStb),
    .fetchAddr(fetchAddr), .cpuWriteStb(cpuWriteStb), .ctl(ctl)
  );

  irq_tmr_core core_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .irq(irq)
  );
endmodule

// File: tb/irq_prescale_timer_tb.sv
`timescale 1ns/1ps
module irq_prescale_timer_tb_top;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        cpuCycleStb = 1'b0, a12RiseStb = 1'b0, fetchStb = 1'b0, cpuWriteStb = 1'b0;
  logic [13:0] fetchAddr = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [7:0]  mPre = 0, mMain = 0, mMode = 0, mKey = 0, mAdj = 0;
  logic        mEn = 0, mIrq = 0;
  logic [13:0] mLast = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_prescale_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpuCycleStb(cpuCycleStb), .a12RiseStb(a12RiseStb), .fetchStb(fetchStb),
    .fetchAddr(fetchAddr), .cpuWriteStb(cpuWriteStb), .irq(irq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at a falling edge, update the model, check at the next falling edge
  task automatic tick(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic c, input logic g, input logic f, input logic [13:0] fa,
                      input logic w, input string tag);
    int st;
    logic ld, ack, wrap;
    logic [7:0] mask;
    wrEn = we; wrAddr = a; wrData = d;
    cpuCycleStb = c; a12RiseStb = g; fetchStb = f; fetchAddr = fa; cpuWriteStb = w;
    ld  = we && (a == 3'd4 || a == 3'd5);
    ack = we && (a == 3'd2 || (a == 3'd0 && !d[0]));
    st = 0;
    if ((mMode[7:6] == 2'b01 || mMode[7:6] == 2'b10) && !ld) begin
      case (mMode[1:0])
        2'd0: st = c;
        2'd1: st = g;
        2'd2: st = (f && fa != mLast) ? 2 : 0;
        default: st = w;
      endcase
    end
    mask = mMode[3] ? mAdj : (mMode[2] ? 8'h07 : 8'hFF);
    wrap = 0;
    for (int k = 0; k < st; k++) begin
      if (mMode[7:6] == 2'b01) begin
        mPre = mPre + 8'd1;
        if ((mPre & mask) == 8'h00) begin mMain = mMain + 8'd1; if (mMain == 8'h00) wrap = 1; end
      end else begin
        mPre = mPre - 8'd1;
        if ((mPre & mask) == mask) begin mMain = mMain - 8'd1; if (mMain == 8'hFF) wrap = 1; end
      end
    end
    if (ack) mIrq = 0;
    else if (wrap && mEn) mIrq = 1;
    if (we) begin
      case (a)
        3'd0: mEn = d[0];
        3'd1: mMode = d;
        3'd2: mEn = 0;
        3'd3: mEn = 1;
        3'd4: mPre = d ^ mKey;
        3'd5: mMain = d ^ mKey;
        3'd6: mKey = d;
        default: mAdj = d;
      endcase
    end
    if (f) mLast = fa;
    @(negedge clk);
    check(tag, irq, mIrq);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    tick(1, a, d, 0, 0, 0, fetchAddr, 0, tag);
  endtask

  task automatic cpuStb(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 1, 0, 0, fetchAddr, 0, tag);
  endtask

  // program counters in clear form (key applied by the bench)
  task automatic setup(input logic [7:0] mode, input logic [7:0] key,
                       input logic [7:0] pre, input logic [7:0] main, input string tag);
    wr(3'd2, 8'h00, tag);
    wr(3'd6, key, tag);
    wr(3'd1, mode, tag);
    wr(3'd4, pre ^ key, tag);
    wr(3'd5, main ^ key, tag);
    wr(3'd3, 8'h00, tag);
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", irq, 1'b0);

    // R1 / R3: mode zero frozen, enable set, every strobe kind
    wr(3'd3, 0, "R1 enable");
    for (int i = 0; i < 600; i++)
      tick(0, 0, 0, 1, 1, 1, 14'(i), 1, "R1 frozen after reset");

    // R3: directions 00 and 11 freeze, then counting proves the values were held
    setup(8'hC4, 8'h00, 8'h06, 8'hFF, "R3 setup");
    cpuStb(40, "R3 freeze 11");
    wr(3'd1, 8'h04, "R3 mode 00");
    cpuStb(40, "R3 freeze 00");
    wr(3'd1, 8'h44, "R3 resume up");
    cpuStb(4, "R3 resume wrap");

    // R2 R6 R7 R8 R9: sweep directions, widths, prescaler start values, keys
    for (int dir = 0; dir < 2; dir++)
      for (int nar = 0; nar < 2; nar++)
        for (int p = 0; p < 8; p++) begin
          logic [7:0] mode, key, pv;
          mode = (dir == 0) ? 8'h40 : 8'h80;
          if (nar != 0) mode = mode | 8'h04;
          key = 8'(p * 37 + dir * 90 + nar * 17);
          pv = (nar != 0) ? 8'(p) : 8'(p * 33);
          setup(mode, key, pv, (dir == 0) ? 8'hFF : 8'h00,
                (dir == 0) ? "R7 setup" : "R8 setup");
          cpuStb((nar != 0) ? 12 : 260, (dir == 0) ? "R7 R9 R6 up" : "R8 R9 R6 down");
          wr(3'd0, 8'h00, "R11 ack via offset0");
        end

    // R9: mode bit 3 selects offset 7 mask, overriding bit 2
    for (int j = 0; j < 4; j++) begin
      logic [7:0] adj;
      adj = (j == 0) ? 8'h00 : (j == 1) ? 8'h01 : (j == 2) ? 8'h0F : 8'h30;
      wr(3'd7, adj, "R9 adj");
      setup((j[0] ? 8'h8C : 8'h4C), 8'h00, 8'h05, (j[0] ? 8'h01 : 8'hFE), "R9 setup");
      cpuStb(80, "R9 adjust mask");
      wr(3'd2, 8'h00, "R9 ack");
    end

    // R4 R5: each source, all strobes toggling
    for (int s = 0; s < 4; s++) begin
      setup(8'h44 | 8'(s), 8'h00, 8'h00, 8'hFE, "R4 setup");
      for (int i = 0; i < 48; i++)
        tick(0, 0, 0, i[0], i[1], i[2] | i[0], 14'(i >> 2), i[3] ^ i[0],
             (s == 2) ? "R5 fetch address change" : "R4 source select");
      wr(3'd2, 8'h00, "R4 ack");
    end
    // R5: repeated address never advances
    setup(8'h46, 8'h00, 8'h07, 8'hFF, "R5 setup");
    for (int i = 0; i < 20; i++) tick(0, 0, 0, 0, 0, 1, 14'h123, 0, "R5 same address");
    tick(0, 0, 0, 0, 0, 1, 14'h124, 0, "R5 new address double step");

    // R10 R11: enable, acknowledge, disabled wrap
    setup(8'h44, 8'h00, 8'h07, 8'hFF, "R10 setup");
    wr(3'd2, 0, "R11 disable");
    cpuStb(3, "R10 disabled wrap no irq");
    wr(3'd4, 8'h07, "R10 reload pre");
    wr(3'd5, 8'hFF, "R10 reload main");
    wr(3'd0, 8'h01, "R11 offset0 enable");
    cpuStb(3, "R10 wrap sets irq");
    cpuStb(20, "R10 irq held");
    wr(3'd3, 0, "R11 offset3 no ack");
    wr(3'd0, 8'h00, "R11 offset0 bit0 clear acks");
    wr(3'd4, 8'h07, "R11 reload");
    wr(3'd5, 8'hFF, "R11 reload");
    wr(3'd3, 0, "R11 enable");
    cpuStb(1, "R11 wrap");
    wr(3'd2, 0, "R11 offset2 acks");
    // ack in the same cycle as a wrap
    wr(3'd4, 8'h06, "R11 reload");
    wr(3'd5, 8'hFF, "R11 reload");
    wr(3'd3, 0, "R11 enable");
    cpuStb(1, "R11 pre step");
    tick(1, 3'd2, 8'h00, 1, 0, 0, 0, 0, "R11 ack beats wrap");
    wr(3'd3, 0, "R11 enable again");
    cpuStb(2, "R11 no stale irq");

    // R12: load in the same cycle as a strobe
    setup(8'h44, 8'h00, 8'h06, 8'hFF, "R12 setup");
    tick(1, 3'd4, 8'h05, 1, 0, 0, 0, 0, "R12 pre load wins");
    tick(1, 3'd5, 8'hFF, 1, 0, 0, 0, 0, "R12 main load wins");
    cpuStb(4, "R12 timing after loads");

    repeat (2) tick(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule